// File: doc/BRIEF.md
# Message Padding Detector

This block sits in the accumulate path of a hashing engine, where a single message is delivered as a sequence of separate requests. It keeps a running byte total across the requests of one message and, for each new request, decides whether that request carries the closing Merkle–Damgård padding. The decision does not trust any end-of-list marker. It works backwards from the 64-bit length field in the request's last eight bytes, finds where the padding must begin, and confirms that position by reading one byte from the request buffer.

When the padding is confirmed, the block reports the request as final and gives the offset where the padding starts. Only the bytes in front of that offset are message data. A final request clears the running total and the count of cached segments, so the next request begins a new message.

Requests enter through a valid/ready handshake. `req_ready` is high only while the block is idle. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. While a request is being evaluated, `req_ready` stays low and the requester must hold off. The result comes back as a one-cycle `done` pulse. The result pins keep their value until the next pulse.

Top module: `msg_pad_detect`

## Requirements
- R1: `req_ready` is high exactly when the block is idle. After an accepting edge it is low until the result for that request has been produced, and a `req_valid` held high during that time is not taken a second time.
- R2: On acceptance, `run_total` grows by `req_len`, modulo 2^32. The new value is visible in the cycle after the accepting edge.
- R3: The message byte length is the trailing field `req_tail`, treated as a big-endian bit count, divided by 8 and truncated to 32 bits. That is, `req_tail` bits 34 down to 3.
- R4: If the message length is greater than the updated running total, the request is not final and no byte read is issued.
- R5: Padding size is the updated running total minus the message length. If the padding size is larger than `req_len`, the request is not final and no byte read is issued.
- R6: Otherwise exactly one read is issued. It is a single-cycle `rd_en` pulse with `rd_addr` equal to `req_len` minus the padding size, which is never above `req_len`.
- R7: The request is final only if the byte returned by that read equals 0x80. `pad_offset` then gives the read address, and it is 0 for a request that is not final.
- R8: `done` is a one-cycle pulse. It appears 1 clock edge after the accepting edge when no read is issued, and RD_LAT+1 edges after it when a read is issued. `rd_data` is taken RD_LAT edges after the `rd_en` cycle.
- R9: A final result sets `run_total` and `seg_count` to 0 in the same cycle as its `done` pulse. A result that is not final increments `seg_count`.
- R10: After reset, `run_total`, `seg_count`, `done`, `final_flag` and `pad_offset` are 0, and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | Block is idle and will take a request |
| req_len | input | W | Request length in bytes |
| req_tail | input | TAIL_W | Last eight bytes of the request as a big-endian value |
| rd_en | output | 1 | Byte read strobe into the request buffer |
| rd_addr | output | W | Byte offset within the request buffer |
| rd_data | input | 8 | Byte returned RD_LAT cycles after the strobe |
| done | output | 1 | One-cycle result pulse |
| final_flag | output | 1 | Last result found padding |
| pad_offset | output | W | Start of padding for a final result, otherwise 0 |
| run_total | output | W | Running byte total of the current message |
| seg_count | output | SEG_W | Requests taken since the last final one |

## Verification
The assertions rely on the buffer answering every `rd_en` with valid `rd_data` after exactly RD_LAT cycles. They also rely on `req_len` being stable only in the accepting cycle, because the block registers it there. The bench meets the first condition with a read model built as an RD_LAT-deep pipeline in front of a byte array that is refilled before each request. It meets the second by changing request fields only on falling edges and only while `req_ready` is high. The back-pressure case holds `req_valid` high through the busy window. The bench confirms through `seg_count` and `run_total` that the request was taken only once.

// File: rtl/mpd_pkg.sv
`timescale 1ns/1ps
package mpd_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EVAL = 2'd1,
    ST_WAIT = 2'd2
  } mpd_state_e;

  localparam logic [7:0] PAD_MARK = 8'h80;
endpackage

// File: rtl/mpd_pad_calc.sv
`timescale 1ns/1ps
// Pure arithmetic: locate where padding would begin inside this request.
module mpd_pad_calc #(
  parameter int W      = 32,
  parameter int TAIL_W = 64
) (
  input  logic [W-1:0]      total,
  input  logic [W-1:0]      len,
  input  logic [TAIL_W-1:0] tail,
  output logic              cand,
  output logic [W-1:0]      offset
);
  localparam int MSG_MSB = W + 2;

  logic [W-1:0] msg_bytes;
  logic [W-1:0] pad_bytes;
  logic         fits_total;
  logic         fits_len;
  logic         unused_tail_bits;

  assign msg_bytes        = tail[MSG_MSB:3];
  assign unused_tail_bits = ^{tail[TAIL_W-1:MSG_MSB+1], tail[2:0]};

  always_comb begin
    fits_total = (msg_bytes <= total);
    pad_bytes  = fits_total ? (total - msg_bytes) : '0;
    fits_len   = fits_total && (pad_bytes <= len);
    cand       = fits_len;
    offset     = fits_len ? (len - pad_bytes) : '0;
  end
endmodule

// File: rtl/mpd_total_acc.sv
`timescale 1ns/1ps
// Running byte total and cached segment count for one message.
module mpd_total_acc #(
  parameter int W     = 32,
  parameter int SEG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             add_en,
  input  logic [W-1:0]     add_len,
  input  logic             clear_en,
  input  logic             seg_inc,
  output logic [W-1:0]     total,
  output logic [SEG_W-1:0] segs
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      total <= '0;
      segs  <= '0;
    end else begin
      if (clear_en) begin
        total <= '0;
        segs  <= '0;
      end else begin
        if (add_en)  total <= total + add_len;
        if (seg_inc) segs  <= segs + 1'b1;
      end
    end
  end

  assert_add_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (add_en && !clear_en) |=> (total == $past(total) + $past(add_len)));

  assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clear_en |=> (total == '0 && segs == '0));
endmodule

// File: rtl/mpd_rd_timer.sv
`timescale 1ns/1ps
// Counts the fixed read latency of the request buffer.
module mpd_rd_timer #(
  parameter int RD_LAT = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  output logic expire
);
  localparam int CNT_W = $clog2(RD_LAT) + 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(RD_LAT - 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)     cnt_q <= '0;
    else if (start) cnt_q <= '0;
    else if (run)   cnt_q <= cnt_q + 1'b1;
  end

  assign expire = run && (cnt_q == LAST);

  assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (cnt_q <= LAST));
endmodule

// File: rtl/msg_pad_detect.sv
`timescale 1ns/1ps
module msg_pad_detect #(
  parameter int W      = 32,
  parameter int TAIL_W = 64,
  parameter int SEG_W  = 8,
  parameter int RD_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [W-1:0]      req_len,
  input  logic [TAIL_W-1:0] req_tail,
  output logic              rd_en,
  output logic [W-1:0]      rd_addr,
  input  logic [7:0]        rd_data,
  output logic              done,
  output logic              final_flag,
  output logic [W-1:0]      pad_offset,
  output logic [W-1:0]      run_total,
  output logic [SEG_W-1:0]  seg_count
);
  import mpd_pkg::*;

  mpd_state_e        state_q;
  logic [W-1:0]      len_q;
  logic [TAIL_W-1:0] tail_q;
  logic [W-1:0]      off_q;
  logic              done_q;
  logic              fin_q;
  logic [W-1:0]      pout_q;

  logic         accept;
  logic         cand;
  logic [W-1:0] cand_off;
  logic         in_eval;
  logic         in_wait;
  logic         expire;
  logic         hit;
  logic         finish_hit;
  logic         finish_miss;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign in_eval   = (state_q == ST_EVAL);
  assign in_wait   = (state_q == ST_WAIT);

  mpd_pad_calc #(.W(W), .TAIL_W(TAIL_W)) u_calc (
    .total  (run_total),
    .len    (len_q),
    .tail   (tail_q),
    .cand   (cand),
    .offset (cand_off)
  );

  mpd_rd_timer #(.RD_LAT(RD_LAT)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .start  (in_eval && cand),
    .run    (in_wait),
    .expire (expire)
  );

  assign hit         = expire && (rd_data == PAD_MARK);
  assign finish_hit  = hit;
  assign finish_miss = (in_eval && !cand) || (expire && !hit);

  mpd_total_acc #(.W(W), .SEG_W(SEG_W)) u_acc (
    .clk      (clk),
    .rst_n    (rst_n),
    .add_en   (accept),
    .add_len  (req_len),
    .clear_en (finish_hit),
    .seg_inc  (finish_miss),
    .total    (run_total),
    .segs     (seg_count)
  );

  assign rd_en   = in_eval && cand;
  assign rd_addr = cand_off;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      len_q   <= '0;
      tail_q  <= '0;
      off_q   <= '0;
      done_q  <= 1'b0;
      fin_q   <= 1'b0;
      pout_q  <= '0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            len_q   <= req_len;
            tail_q  <= req_tail;
            state_q <= ST_EVAL;
          end
        end
        ST_EVAL: begin
          if (cand) begin
            off_q   <= cand_off;
            state_q <= ST_WAIT;
          end else begin
            done_q  <= 1'b1;
            fin_q   <= 1'b0;
            pout_q  <= '0;
            state_q <= ST_IDLE;
          end
        end
        ST_WAIT: begin
          if (expire) begin
            done_q  <= 1'b1;
            fin_q   <= hit;
            pout_q  <= hit ? off_q : '0;
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign done       = done_q;
  assign final_flag = fin_q;
  assign pad_offset = pout_q;

  assert_busy_after_accept_R1: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !req_ready);

  assert_read_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en);

  assert_read_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (rd_addr <= len_q));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_result_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(final_flag) && $stable(pad_offset)));

  assert_final_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && final_flag) |-> (run_total == '0 && seg_count == '0));

  assert_no_offset_when_open_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !final_flag) |-> (pad_offset == '0));
endmodule

// File: tb/msg_pad_detect_test.sv
`timescale 1ns/1ps
module msg_pad_detect_test;
  localparam int RD_LAT = 2;
  localparam int NV     = 10;

  typedef struct packed {
    logic [31:0] len;
    logic [63:0] tail;
    logic [7:0]  mpos;
    logic [7:0]  mval;
    logic        fin;
    logic [31:0] off;
    logic [31:0] tot;
    logic [7:0]  seg;
    logic        rd;
  } vec_t;

  // len, tail, marker pos, marker byte, final, offset, total after, segs after, read issued
  localparam vec_t VECS [NV] = '{
    '{32'd16, 64'd0,    8'd0,  8'h00, 1'b0, 32'd0,  32'd16, 8'd1, 1'b1},
    '{32'd32, 64'd320,  8'd24, 8'h80, 1'b1, 32'd24, 32'd0,  8'd0, 1'b1},
    '{32'd20, 64'd800,  8'd0,  8'h80, 1'b0, 32'd0,  32'd20, 8'd1, 1'b0},
    '{32'd8,  64'd0,    8'd0,  8'h80, 1'b0, 32'd0,  32'd28, 8'd2, 1'b0},
    '{32'd12, 64'd240,  8'd2,  8'h81, 1'b0, 32'd0,  32'd40, 8'd3, 1'b1},
    '{32'd10, 64'd360,  8'd5,  8'h80, 1'b1, 32'd5,  32'd0,  8'd0, 1'b1},
    '{32'd64, 64'd512,  8'd64, 8'h80, 1'b1, 32'd64, 32'd0,  8'd0, 1'b1},
    '{32'd10, 64'h0000_0100_0000_0018, 8'd3, 8'h80, 1'b1, 32'd3, 32'd0, 8'd0, 1'b1},
    '{32'd8,  64'd0,    8'd0,  8'h80, 1'b1, 32'd0,  32'd0,  8'd0, 1'b1},
    '{32'd4,  64'd16,   8'd2,  8'h80, 1'b1, 32'd2,  32'd0,  8'd0, 1'b1}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_len = '0;
  logic [63:0] req_tail = '0;
  logic        rd_en;
  logic [31:0] rd_addr;
  logic [7:0]  rd_data;
  logic        done;
  logic        final_flag;
  logic [31:0] pad_offset;
  logic [31:0] run_total;
  logic [7:0]  seg_count;

  int checks = 0;
  int errors = 0;
  int reads  = 0;

  logic [7:0] mem [128];
  logic [7:0] pipe [RD_LAT];

  always #4 clk = ~clk;

  msg_pad_detect #(.W(32), .TAIL_W(64), .SEG_W(8), .RD_LAT(RD_LAT)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_len(req_len), .req_tail(req_tail), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .done(done), .final_flag(final_flag),
    .pad_offset(pad_offset), .run_total(run_total), .seg_count(seg_count)
  );

  // Buffer model: data appears RD_LAT edges after the strobe cycle.
  always_ff @(posedge clk) begin
    pipe[0] <= mem[rd_addr[6:0]];
    for (int k = 1; k < RD_LAT; k++) pipe[k] <= pipe[k-1];
    if (rd_en) reads <= reads + 1;
  end
  assign rd_data = pipe[RD_LAT-1];

  task automatic check(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_up();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic fill_mem(input logic [7:0] pos, input logic [7:0] val);
    for (int k = 0; k < 128; k++) mem[k] = 8'h00;
    mem[pos[6:0]] = val;
  endtask

  // Drive one request, return edges from acceptance to the done pulse.
  task automatic send(input logic [31:0] len, input logic [63:0] tail, output int edges);
    @(negedge clk);
    req_valid = 1'b1;
    req_len   = len;
    req_tail  = tail;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    edges = 0;
    while (!done && edges < 100) begin
      @(negedge clk);
      edges++;
    end
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finish_up();
  end

  initial begin
    int edges;
    int r0;
    for (int k = 0; k < RD_LAT; k++) pipe[k] = 8'h00;
    fill_mem(8'd0, 8'h00);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10: reset state
    check("R10", "req_ready", req_ready, 1);
    check("R10", "run_total", run_total, 0);
    check("R10", "seg_count", seg_count, 0);
    check("R10", "done/final", {done, final_flag}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R2..R9
    for (int i = 0; i < NV; i++) begin
      fill_mem(VECS[i].mpos, VECS[i].mval);
      r0 = reads;
      check("R1", "ready before request", req_ready, 1);
      send(VECS[i].len, VECS[i].tail, edges);
      check("R8", $sformatf("v%0d done latency", i), edges, VECS[i].rd ? RD_LAT + 1 : 1);
      check("R7", $sformatf("v%0d final", i), final_flag, VECS[i].fin);
      check("R7", $sformatf("v%0d offset", i), pad_offset, VECS[i].off);
      check("R2_R9", $sformatf("v%0d run_total", i), run_total, VECS[i].tot);
      check("R9", $sformatf("v%0d seg_count", i), seg_count, VECS[i].seg);
      check("R4_R5_R6", $sformatf("v%0d reads", i), reads - r0, VECS[i].rd ? 1 : 0);
      @(negedge clk);
      check("R8", $sformatf("v%0d done one cycle", i), done, 0);
    end

    // R3: truncation already in v7; R1: back-pressure with held valid
    fill_mem(8'd0, 8'h00);
    @(negedge clk);
    req_valid = 1'b1;
    req_len   = 32'd6;
    req_tail  = 64'd0;
    @(posedge clk);
    @(negedge clk);
    check("R1", "ready low while busy", req_ready, 0);
    @(negedge clk);
    check("R1", "ready still low", req_ready, 0);
    @(negedge clk);
    req_valid = 1'b0;
    edges = 0;
    while (!done && edges < 100) begin
      @(negedge clk);
      edges++;
    end
    check("R1", "single accept total", run_total, 6);
    check("R1", "single accept segs", seg_count, 1);
    @(negedge clk);
    check("R1", "ready after result", req_ready, 1);

    // R10: reset clears accumulated state
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check("R10", "total after reset", run_total, 0);
    check("R10", "segs after reset", seg_count, 0);
    check("R10", "offset after reset", pad_offset, 0);
    rst_n = 1'b1;
    @(negedge clk);
    finish_up();
  end
endmodule